// File: doc/BRIEF.md
# Interconnect Test Vector Generator

This block produces the parallel stimulus used to check a set of boundary-scan-driven board nets for opens and shorts. Each of the `NETS` nets is given its own code word. The generator emits one vector per step. Step `j` gathers bit `j` of every net's code, so that the nets are applied together as one wide word. The codes are the consecutive values 1 to `NETS`. This means no net is ever held at all-zeros or all-ones for the whole sequence. Every net therefore sees both logic levels, and any two nets disagree in at least one step.

The number of vectors is the smallest that guarantees this: the ceiling of log2(`NETS`+2). The generator works it out when the design is elaborated. A pulse on `start_i` while the block is idle begins a sequence. Each vector is held on a valid/ready handshake until it is accepted, and the final vector is flagged. Comparing the responses and diagnosing faults are the job of downstream logic.

Top module: `intercon_vec_gen`

## Requirements
- R1: While reset is asserted and after it is released, `vec_valid_o` and `vec_last_o` are low until a start is accepted.
- R2: Each sequence has exactly VC = ceil(log2(NETS+2)) accepted vectors, after which `vec_valid_o` falls.
- R3: Vector number j (counting from 0) has, at bit position i, bit j of the binary value i+1. Net 0 sits in bit 0, the least significant bit.
- R4: `vec_last_o` is high only together with `vec_valid_o`, and only while the final vector (j = VC-1) is offered.
- R5: Over one sequence, every bit position of `vec_data_o` takes the value 0 at least once and the value 1 at least once.
- R6: Over one sequence, every pair of bit positions of `vec_data_o` has opposite values in at least one vector.
- R7: While `vec_valid_o` is high and `vec_ready_i` is low, `vec_data_o`, `vec_last_o` and `vec_valid_o` hold their values at the next clock edge.
- R8: A start that arrives while a sequence is running is ignored. No second sequence follows, and the running one is not restarted.
- R9: A start accepted while idle raises `vec_valid_o` at the next clock edge, offering vector 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a sequence when the block is idle |
| vec_ready_i | input | 1 | Consumer accepts the offered vector |
| vec_valid_o | output | 1 | A vector is offered |
| vec_data_o | output | NETS | Drive values for the nets; bit i belongs to net i |
| vec_last_o | output | 1 | The offered vector is the last of the sequence |

## Verification
The assertions assume that `start_i` and `vec_ready_i` are clean, synchronous levels. They also assume that the consumer may withdraw `vec_ready_i` at any time without breaking the protocol. The checker therefore follows its own step count only through accepted handshakes and makes no demand on how soon ready arrives. The stimulus drives both inputs on the falling edge. It varies ready with always-on, alternating, sparse and irregular patterns. It also raises start in the middle of a sequence, including on the edge that accepts the last vector, so that the ignore rule is tested at its boundary.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } ivg_state_t;

   // smallest k with 2**k >= nets+2
   function automatic int vec_count(input int nets);
      return $clog2(nets + 2);
   endfunction

   function automatic int step_width(input int vcount);
      return (vcount > 1) ? $clog2(vcount) : 1;
   endfunction

endpackage

// File: rtl/ivg_code_matrix.sv
module ivg_code_matrix #(
   parameter int NETS   = 8,
   parameter int VCOUNT = 4
) (
   output logic [VCOUNT-1:0][NETS-1:0] mat_o
);
   for (genvar j = 0; j < VCOUNT; j++) begin : g_vec
      for (genvar i = 0; i < NETS; i++) begin : g_net
         localparam int unsigned CODE = i + 1;
         localparam logic        BITV = ((CODE >> j) & 1) != 0;
         assign mat_o[j][i] = BITV;
      end
   end
endmodule

// File: rtl/ivg_seq_ctrl.sv
module ivg_seq_ctrl
   import ivg_pkg::*;
#(
   parameter int VCOUNT = 4,
   parameter int STEP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic              last_o,
   output logic              load_o,
   output logic [STEP_W-1:0] step_o,
   output logic [STEP_W-1:0] step_nxt_o
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(VCOUNT - 1);

   ivg_state_t        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic              fire, at_last;

   assign fire    = (state_q == ST_RUN) && ready_i;
   assign at_last = (step_q == LAST_STEP);

   always_comb begin
      state_d = state_q;
      step_d  = step_q;
      load_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_RUN;
               step_d  = '0;
               load_o  = 1'b1;
            end
         end
         ST_RUN: begin
            if (fire) begin
               if (at_last) begin
                  state_d = ST_IDLE;
               end else begin
                  step_d = step_q + 1'b1;
                  load_o = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   assign valid_o    = (state_q == ST_RUN);
   assign last_o     = valid_o && at_last;
   assign step_o     = step_q;
   assign step_nxt_o = step_d;
endmodule

// File: rtl/ivg_vec_out.sv
module ivg_vec_out #(
   parameter int NETS    = 8,
   parameter int VCOUNT  = 4,
   parameter int STEP_W  = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [VCOUNT-1:0][NETS-1:0] mat_i,
   input  logic                        load_i,
   input  logic [STEP_W-1:0]           step_i,
   input  logic [STEP_W-1:0]           step_nxt_i,
   output logic [NETS-1:0]             data_o
);
   if (OUT_REG) begin : g_reg
      logic [NETS-1:0] data_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      data_q <= '0;
         else if (load_i) data_q <= mat_i[step_nxt_i];
      end
      assign data_o = data_q;
   end else begin : g_mux
      assign data_o = mat_i[step_i];
   end
endmodule

// File: rtl/intercon_vec_gen.sv
module intercon_vec_gen
   import ivg_pkg::*;
#(
   parameter int NETS    = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            vec_ready_i,
   output logic            vec_valid_o,
   output logic [NETS-1:0] vec_data_o,
   output logic            vec_last_o
);
   localparam int VCOUNT = vec_count(NETS);
   localparam int STEP_W = step_width(VCOUNT);

   if (NETS < 1) begin : g_bad_nets
      $error("intercon_vec_gen: NETS must be at least 1");
   end
   if (VCOUNT > 31) begin : g_bad_vc
      $error("intercon_vec_gen: NETS too large for code width");
   end

   logic [VCOUNT-1:0][NETS-1:0] mat;
   logic                        load;
   logic [STEP_W-1:0]           step, step_nxt;

   ivg_code_matrix #(.NETS(NETS), .VCOUNT(VCOUNT)) u_mat (
      .mat_o (mat)
   );

   ivg_seq_ctrl #(.VCOUNT(VCOUNT), .STEP_W(STEP_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .ready_i    (vec_ready_i),
      .valid_o    (vec_valid_o),
      .last_o     (vec_last_o),
      .load_o     (load),
      .step_o     (step),
      .step_nxt_o (step_nxt)
   );

   ivg_vec_out #(
      .NETS(NETS), .VCOUNT(VCOUNT), .STEP_W(STEP_W), .OUT_REG(OUT_REG)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .mat_i      (mat),
      .load_i     (load),
      .step_i     (step),
      .step_nxt_i (step_nxt),
      .data_o     (vec_data_o)
   );
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker #(
   parameter int NETS = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            vec_ready_i,
   input logic            vec_valid_o,
   input logic [NETS-1:0] vec_data_o,
   input logic            vec_last_o
);
   localparam int VC = $clog2(NETS + 2);

   int unsigned     acc_cnt;
   logic [NETS-1:0] exp_vec;
   logic            fire;

   assign fire = vec_valid_o && vec_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  acc_cnt <= 0;
      else if (fire && vec_last_o) acc_cnt <= 0;
      else if (fire)               acc_cnt <= acc_cnt + 1;
   end

   always_comb begin
      for (int i = 0; i < NETS; i++) begin
         exp_vec[i] = (((i + 1) >> acc_cnt) & 1) != 0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_idle_in_reset_R1: assert (!vec_valid_o && !vec_last_o);
      end
   end

   assert_count_at_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vec_last_o |-> acc_cnt == VC - 1);

   assert_vector_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |-> vec_data_o == exp_vec);

   assert_last_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_last_o |-> vec_valid_o);

   assert_drop_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && vec_last_o) |=> !vec_valid_o);

   assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && !vec_ready_i) |=>
         (vec_valid_o && $stable(vec_data_o) && $stable(vec_last_o)));

   assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid_o && start_i && !fire) |=> (vec_valid_o && acc_cnt == $past(acc_cnt)));

   assert_start_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_valid_o && start_i) |=> (vec_valid_o && acc_cnt == 0));
endmodule

bind intercon_vec_gen ivg_checker #(.NETS(NETS)) u_ivg_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .vec_ready_i (vec_ready_i),
   .vec_valid_o (vec_valid_o),
   .vec_data_o  (vec_data_o),
   .vec_last_o  (vec_last_o)
);

// File: tb/tb_intercon_vec_gen.sv
`timescale 1ns/1ps
module tb_intercon_vec_gen;
   localparam int NETS = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_i = 1'b0;
   logic            vec_ready_i = 1'b0;
   logic            vec_valid_o;
   logic [NETS-1:0] vec_data_o;
   logic            vec_last_o;

   int checks = 0;
   int failures = 0;
   int vc_exp;
   bit finished = 1'b0;
   logic [NETS-1:0] got [0:31];

   always #2 clk = ~clk;

   intercon_vec_gen #(.NETS(NETS), .OUT_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_ready_i(vec_ready_i),
      .vec_valid_o(vec_valid_o), .vec_data_o(vec_data_o), .vec_last_o(vec_last_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [NETS-1:0] exp_vec(input int j);
      logic [NETS-1:0] v;
      for (int i = 0; i < NETS; i++) v[i] = (((i + 1) >> j) & 1) != 0;
      return v;
   endfunction

   function automatic bit pick_ready(input int mode, input int c);
      case (mode)
         0: return 1'b1;
         1: return (c % 2) == 1;
         2: return (c % 3) == 2;
         default: return ((c * 5 + 3) % 7) < 3;
      endcase
   endfunction

   task automatic run_seq(input int mode, input int poke_at);
      int n = 0;
      bit done = 1'b0;
      bit stalled = 1'b0;
      logic [NETS-1:0] prev = '0;
      logic            rdy;
      @(negedge clk); start_i = 1'b1; vec_ready_i = 1'b0;
      @(negedge clk); start_i = 1'b0;
      chk(vec_valid_o === 1'b1, "R9 valid after start", int'(vec_valid_o), 1);
      for (int c = 0; c < 80 && !done; c++) begin
         rdy = pick_ready(mode, c);
         if (stalled)
            chk(vec_valid_o === 1'b1 && vec_data_o === prev, "R7 hold while stalled",
                int'(vec_data_o), int'(prev));
         start_i     = (c == poke_at);
         vec_ready_i = rdy;
         if (vec_valid_o && rdy) begin
            chk(vec_data_o === exp_vec(n), "R3 vector bits", int'(vec_data_o), int'(exp_vec(n)));
            chk(vec_last_o === (n == vc_exp - 1), "R4 last flag", int'(vec_last_o),
                int'(n == vc_exp - 1));
            got[n] = vec_data_o;
            n++;
            if (vec_last_o) done = 1'b1;
         end else if (vec_valid_o) begin
            chk(vec_last_o === (n == vc_exp - 1), "R4 last while stalled", int'(vec_last_o),
                int'(n == vc_exp - 1));
         end
         stalled = vec_valid_o && !rdy;
         prev    = vec_data_o;
         @(negedge clk);
      end
      start_i = 1'b0; vec_ready_i = 1'b0;
      chk(n == vc_exp, "R2 vector count", n, vc_exp);
      chk(vec_valid_o === 1'b0 && vec_last_o === 1'b0, "R2 valid drops after last",
          int'(vec_valid_o), 0);
      for (int i = 0; i < NETS; i++) begin
         bit s0 = 1'b0, s1 = 1'b0;
         for (int j = 0; j < n; j++) begin
            if (got[j][i]) s1 = 1'b1; else s0 = 1'b1;
         end
         chk(s0 && s1, "R5 net sees 0 and 1", int'({s1, s0}), 3);
      end
      for (int a = 0; a < NETS; a++) begin
         for (int b = a + 1; b < NETS; b++) begin
            bit sep = 1'b0;
            for (int j = 0; j < n; j++) if (got[j][a] != got[j][b]) sep = 1'b1;
            chk(sep, "R6 pair separated", int'(sep), 1);
         end
      end
      repeat (3) @(negedge clk);
      chk(vec_valid_o === 1'b0, "R8 no restart from busy start", int'(vec_valid_o), 0);
   endtask

   initial begin
      vc_exp = 0;
      while ((1 << vc_exp) < NETS + 2) vc_exp++;
      repeat (3) @(negedge clk);
      chk(vec_valid_o === 1'b0 && vec_last_o === 1'b0, "R1 idle in reset", int'(vec_valid_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(vec_valid_o === 1'b0 && vec_last_o === 1'b0, "R1 idle after reset", int'(vec_valid_o), 0);
      for (int m = 0; m < 4; m++) run_seq(m, -1);
      run_seq(0, 1);
      run_seq(0, 2);
      run_seq(1, 3);
      run_seq(3, 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule